// File: doc/BRIEF.md
# Chained FIFO Depth-Expansion Token Controller

This block sits beside the storage array of one FIFO device and decides whether that device may take part in a write or a read. Several identical devices can be wired into a ring to act as one deeper FIFO. A write token and a read token travel around the ring separately. The device holding the write token accepts writes into its own array, starting at location zero. When it writes its last physical location it gives up the token, and a one-cycle pulse on its write-pass output hands the token to the next device. The read token moves the same way on the read side. The controller produces the local write and read addresses, the permits for the core, and the enable for the shared output bus.

With the chain-mode strap low the device works on its own. It keeps both tokens permanently and its pointers wrap to zero. Its write-pass output then carries a registered half-full indication instead of pulses. The storage array, empty/full detection and any flags combined across devices are built outside this block. Write and read share one clock; all state uses a synchronous active-high reset.

Top module: `xchain_ctrl`

## Requirements
- R1: During reset, the leading device (`follower` low) and every solo device hold both tokens, so `wr_permit` and `rd_permit` are 1. A follower in ring mode holds neither token. Both addresses are 0 and `wx_out`/`rx_out` are 0.
- R2: The address of a token holder advances by one, modulo DEPTH, on each clock edge that sees its enable high, and it holds when the enable is low.
- R3: A device without the write token ignores `wr_en`: `wr_permit` stays 0 and `wr_addr` is unchanged after the edge.
- R4: In ring mode, a write accepted at address DEPTH-1 makes `wx_out` 1 for exactly the next cycle. From that cycle on, `wr_permit` is 0 and `wr_addr` is 0. The read side behaves the same way on `rx_out`, `rd_permit` and `rd_addr`.
- R5: The read-side hand-off of R4 is checked separately: a read accepted at address DEPTH-1 raises `rx_out` for one cycle and drops `rd_permit`.
- R6: In ring mode, a device without a token that samples its expansion input high on a clock edge holds that token after the edge, with the matching address 0.
- R7: A device without the read token ignores `rd_en`: `rd_permit` stays 0 and `rd_addr` is unchanged after the edge.
- R8: `q_drive` equals `out_en` AND (holding the read token OR `rx_out` high). The last word read before a hand-off therefore stays driven for one more cycle, and at most one device of a ring drives the bus.
- R9: In solo mode (`ring_mode` low) the pointers wrap from DEPTH-1 to 0 and the tokens are kept. `rx_out` stays 0. `wx_out` is 1 exactly when the number of stored words after the last edge is greater than DEPTH/2.
- R10: In a ring of devices, exactly one device at a time holds each token or has its pass pulse in flight. Words written back to back come out of the ring in write order across device boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common write/read clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_mode | input | 1 | Strap: 1 = device is part of a ring, 0 = solo |
| follower | input | 1 | Strap: 0 = leading device (holds tokens at reset), 1 = other ring devices |
| wx_in | input | 1 | Write-token pass pulse from the previous device |
| rx_in | input | 1 | Read-token pass pulse from the previous device |
| wr_en | input | 1 | Write request, shared by all devices |
| rd_en | input | 1 | Read request, shared by all devices |
| out_en | input | 1 | Output enable for the shared data bus |
| wr_permit | output | 1 | Device holds the write token |
| rd_permit | output | 1 | Device holds the read token |
| wr_addr | output | $clog2(DEPTH) | Local write location |
| rd_addr | output | $clog2(DEPTH) | Local read location |
| wx_out | output | 1 | Write-token pass pulse (ring) or half-full (solo) |
| rx_out | output | 1 | Read-token pass pulse (ring) |
| q_drive | output | 1 | This device drives the shared output bus |

## Verification
The bench goes after the hand-off edges. These are the write or read at address DEPTH-1, the bubble cycle when a token is in flight, and the receiving device's first access at location zero. If the token is dropped without a pulse, writes stall for good. If the pass pulse lasts two cycles, two devices end up holding one token, and the uniqueness count catches it. If the address does not restart at zero, words come out of the ring in the wrong order. Three more cases are targeted. Requests made while a device has no token must not move its pointer. Solo mode must wrap without ever giving the token away. The half-full output must stay low at exactly DEPTH/2 words and rise at DEPTH/2+1, so an off-by-one comparison shows up at that boundary.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic {
    XC_SOLO = 1'b0,
    XC_RING = 1'b1
  } xc_mode_e;
endpackage

// File: rtl/xc_token_port.sv
module xc_token_port
  import xc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  xc_mode_e      mode,
  input  logic          lead,
  input  logic          req,
  input  logic          tok_in,
  output logic          permit,
  output logic [AW-1:0] addr,
  output logic          tok_out
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          held;
  logic          pulse;
  logic [AW-1:0] ptr;
  logic          ring;
  logic          use_now;
  logic          at_last;

  assign ring    = (mode == XC_RING);
  assign use_now = req & held;
  assign at_last = (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= lead | ~ring;
      ptr   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (use_now) begin
        ptr <= at_last ? '0 : ptr + 1'b1;
        if (at_last && ring) begin
          held  <= 1'b0;
          pulse <= 1'b1;
        end
      end else if (ring && tok_in && !held) begin
        held <= 1'b1;
      end
    end
  end

  assign permit  = held;
  assign addr    = ptr;
  assign tok_out = pulse;

  // R4
  hand_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ring && req && permit && addr == LAST) |=> (tok_out && !permit && addr == '0));
  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    tok_out |=> !tok_out);
  // R3
  idle_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    !permit |=> addr == $past(addr));
  // R6
  take_chk: assert property (@(posedge clk) disable iff (rst)
    (ring && !permit && tok_in) |=> (permit && addr == '0));
  // R9
  solo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ring |=> (permit && !tok_out));
endmodule

// File: rtl/xc_fill_meter.sv
module xc_fill_meter #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic above_half
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    case ({inc, dec})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      above_half <= 1'b0;
    end else begin
      cnt        <= cnt_nx;
      above_half <= (cnt_nx > HALF);
    end
  end

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R9
  half_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt == HALF) |=> above_half);
endmodule

// File: rtl/xchain_ctrl.sv
module xchain_ctrl
  import xc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ring_mode,
  input  logic          follower,
  input  logic          wx_in,
  input  logic          rx_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          out_en,
  output logic          wr_permit,
  output logic          rd_permit,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          wx_out,
  output logic          rx_out,
  output logic          q_drive
);
  xc_mode_e mode;
  logic     lead;
  logic     wr_pass;
  logic     rd_pass;
  logic     half_over;

  assign mode = ring_mode ? XC_RING : XC_SOLO;
  assign lead = ~follower;

  xc_token_port #(.DEPTH(DEPTH)) wr_side (
    .clk(clk), .rst(rst), .mode(mode), .lead(lead), .req(wr_en),
    .tok_in(wx_in), .permit(wr_permit), .addr(wr_addr), .tok_out(wr_pass)
  );

  xc_token_port #(.DEPTH(DEPTH)) rd_side (
    .clk(clk), .rst(rst), .mode(mode), .lead(lead), .req(rd_en),
    .tok_in(rx_in), .permit(rd_permit), .addr(rd_addr), .tok_out(rd_pass)
  );

  xc_fill_meter #(.DEPTH(DEPTH)) meter (
    .clk(clk), .rst(rst),
    .inc(wr_en & wr_permit), .dec(rd_en & rd_permit),
    .above_half(half_over)
  );

  assign wx_out  = (mode == XC_RING) ? wr_pass : half_over;
  assign rx_out  = rd_pass;
  assign q_drive = out_en & (rd_permit | rd_pass);

  // R9
  solo_rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == XC_SOLO) |-> !rx_out);
  // R8
  drive_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == XC_RING && rx_out) |-> !rd_permit);
  // R5
  rd_hand_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == XC_RING && rd_en && rd_permit && rd_addr == AW'(DEPTH - 1))
      |=> (rx_out && !rd_permit));
endmodule

// File: tb/xchain_ctrl_test.sv
module xchain_ctrl_test;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam int N  = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst = 1'b1;

  int nvec = 0;
  int nbad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // solo device
  logic u_wr = 1'b0, u_rd = 1'b0;
  logic u_wp, u_rp, u_wx, u_rx, u_qd;
  logic [AW-1:0] u_wa, u_ra;

  xchain_ctrl #(.DEPTH(D)) uut (
    .clk(clk), .rst(rst), .ring_mode(1'b0), .follower(1'b0),
    .wx_in(1'b0), .rx_in(1'b0), .wr_en(u_wr), .rd_en(u_rd), .out_en(1'b1),
    .wr_permit(u_wp), .rd_permit(u_rp), .wr_addr(u_wa), .rd_addr(u_ra),
    .wx_out(u_wx), .rx_out(u_rx), .q_drive(u_qd)
  );

  // ring of three devices
  logic c_wr = 1'b0, c_rd = 1'b0, c_oe = 1'b1;
  logic [15:0] din = '0;
  logic [N-1:0] c_wp, c_rp, c_wx, c_rx, c_qd;
  logic [AW-1:0] c_wa [N];
  logic [AW-1:0] c_ra [N];

  for (genvar g = 0; g < N; g++) begin : g_ring
    xchain_ctrl #(.DEPTH(D)) dev (
      .clk(clk), .rst(rst), .ring_mode(1'b1), .follower(g != 0),
      .wx_in(c_wx[(g + N - 1) % N]), .rx_in(c_rx[(g + N - 1) % N]),
      .wr_en(c_wr), .rd_en(c_rd), .out_en(c_oe),
      .wr_permit(c_wp[g]), .rd_permit(c_rp[g]), .wr_addr(c_wa[g]), .rd_addr(c_ra[g]),
      .wx_out(c_wx[g]), .rx_out(c_rx[g]), .q_drive(c_qd[g])
    );
  end

  // storage and output registers of each device (outside the block)
  logic [15:0] mem [N][D];
  logic [15:0] qreg [N];
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) qreg[i] <= '0;
      else begin
        if (c_wr && c_wp[i]) mem[i][c_wa[i]] <= din;
        if (c_rd && c_rp[i]) qreg[i] <= mem[i][c_ra[i]];
      end
    end
  end

  // previous-cycle snapshot
  logic [N-1:0] p_wp, p_rp, p_wx, p_rx;
  logic [AW-1:0] p_wa [N];
  logic [AW-1:0] p_ra [N];
  bit p_wr, p_rd, p_rdacc;
  logic [15:0] p_exp;
  logic [15:0] qv [64];
  int qh = 0, qt = 0, cnt = 0;

  task automatic snap();
    p_wp = c_wp; p_rp = c_rp; p_wx = c_wx; p_rx = c_rx;
    for (int i = 0; i < N; i++) begin
      p_wa[i] = c_wa[i]; p_ra[i] = c_ra[i];
    end
    p_wr = c_wr; p_rd = c_rd;
  endtask

  task automatic check_ring();
    int nw, nr, nd, up;
    logic [15:0] bus;
    nw = 0; nr = 0; nd = 0; bus = '0;
    for (int i = 0; i < N; i++) begin
      up = (i + N - 1) % N;
      if (p_wp[i]) begin
        if (p_wr && p_wa[i] == AW'(D - 1))
          chk(c_wx[i] && !c_wp[i] && c_wa[i] == '0, "R4 write hand-off", {c_wx[i], c_wp[i]}, 2);
        else if (p_wr)
          chk(c_wp[i] && c_wa[i] == AW'(p_wa[i] + 1'b1), "R2 write address step", c_wa[i], AW'(p_wa[i] + 1'b1));
        else
          chk(c_wp[i] && c_wa[i] == p_wa[i], "R2 write address hold", c_wa[i], p_wa[i]);
      end else if (p_wx[up])
        chk(c_wp[i] && c_wa[i] == '0, "R6 write token taken", {c_wp[i], c_wa[i]}, 16);
      else
        chk(!c_wp[i] && c_wa[i] == p_wa[i], "R3 write ignored without token", c_wa[i], p_wa[i]);

      if (p_rp[i]) begin
        if (p_rd && p_ra[i] == AW'(D - 1))
          chk(c_rx[i] && !c_rp[i] && c_ra[i] == '0, "R5 read hand-off", {c_rx[i], c_rp[i]}, 2);
        else if (p_rd)
          chk(c_rp[i] && c_ra[i] == AW'(p_ra[i] + 1'b1), "R2 read address step", c_ra[i], AW'(p_ra[i] + 1'b1));
        else
          chk(c_rp[i] && c_ra[i] == p_ra[i], "R2 read address hold", c_ra[i], p_ra[i]);
      end else if (p_rx[up])
        chk(c_rp[i] && c_ra[i] == '0, "R6 read token taken", {c_rp[i], c_ra[i]}, 16);
      else
        chk(!c_rp[i] && c_ra[i] == p_ra[i], "R7 read ignored without token", c_ra[i], p_ra[i]);

      nw += int'(c_wp[i]) + int'(c_wx[i]);
      nr += int'(c_rp[i]) + int'(c_rx[i]);
      chk(c_qd[i] == (c_oe && (c_rp[i] || c_rx[i])), "R8 bus drive enable", c_qd[i], c_oe && (c_rp[i] || c_rx[i]));
      if (c_qd[i]) begin
        nd++;
        bus |= qreg[i];
      end
    end
    chk(nw == 1, "R10 single write token", nw, 1);
    chk(nr == 1, "R10 single read token", nr, 1);
    if (p_rdacc) chk(bus == p_exp && nd == 1, "R10 data order", bus, p_exp);
  endtask

  task automatic ustep(input bit w, input bit r);
    u_wr = w; u_rd = r;
    @(negedge clk);
    u_wr = 1'b0; u_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(u_wp && u_rp && u_wa == '0 && u_ra == '0 && !u_wx && !u_rx, "R1 solo reset", {u_wp, u_rp, u_wx, u_rx}, 12);
    chk(c_wp == 3'b001 && c_rp == 3'b001, "R1 ring token owners", {c_wp, c_rp}, 9);
    chk(c_wx == '0 && c_rx == '0, "R1 ring pulses idle", {c_wx, c_rx}, 0);
    chk(c_qd == 3'b001, "R1 leading device drives bus", c_qd, 1);
    rst = 1'b0;
    @(negedge clk);

    // solo device, R9 and R2
    repeat (8) ustep(1'b1, 1'b0);
    chk(u_wa == AW'(8), "R2 solo write address", u_wa, 8);
    chk(!u_wx, "R9 half-full low at exactly half", u_wx, 0);
    ustep(1'b1, 1'b0);
    chk(u_wx, "R9 half-full high above half", u_wx, 1);
    ustep(1'b0, 1'b1);
    chk(!u_wx, "R9 half-full falls after read", u_wx, 0);
    chk(u_ra == AW'(1), "R2 solo read address", u_ra, 1);
    repeat (7) ustep(1'b1, 1'b0);
    chk(u_wa == '0 && u_wp, "R9 solo write wrap keeps token", {u_wp, u_wa}, 16);
    chk(u_wx, "R9 half-full with 15 words", u_wx, 1);
    for (int k = 0; k < 15; k++) begin
      ustep(1'b0, 1'b1);
      chk(!u_rx && u_rp, "R9 solo read never passes token", {u_rx, u_rp}, 1);
    end
    chk(u_ra == '0 && !u_wx, "R9 solo read wrap and half-full low", {u_wx, u_ra}, 0);

    // ring, random traffic with directed phases
    snap();
    p_rdacc = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int wpct;
      bit wacc, racc;
      check_ring();
      chk(!u_rx, "R9 solo rx stays low", u_rx, 0);
      wpct = (cyc < 1200) ? 85 : (cyc < 2400) ? 15 : (cyc < 3000) ? 100 : 50;
      c_wr = ($urandom_range(99) < wpct) && (cnt < N * D);
      c_rd = ($urandom_range(99) < (cyc >= 2400 && cyc < 3000 ? 0 : 100 - wpct)) && (cnt > 0);
      din  = 16'($urandom);
      wacc = c_wr && (c_wp != '0);
      racc = c_rd && (c_rp != '0);
      if (racc) begin
        p_exp = qv[qh];
        qh = (qh + 1) % 64;
        cnt--;
      end
      if (wacc) begin
        qv[qt] = din;
        qt = (qt + 1) % 64;
        cnt++;
      end
      snap();
      p_rdacc = racc;
      @(negedge clk);
    end
    check_ring();

    // R8 output enable low releases the bus everywhere
    c_wr = 1'b0; c_rd = 1'b0; c_oe = 1'b0;
    @(negedge clk);
    chk(c_qd == '0, "R8 bus released when output disabled", c_qd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule